// File: doc/BRIEF.md
# Trigger-Gated Programmable Timer

This block is a programmable down-counter that supplies the shift clock and the load/unload strobe for a bank of shift registers. One 16-bit count register serves three count-and-reload schemes: a plain wide counter, a split counter whose low byte divides the bit rate and whose high byte counts bits, and a two-phase PWM whose low byte sets the high time and whose high byte sets the low time. The counter steps on the module clock, on every edge of an external pin, or on rising edges of a trigger.

A trigger line, taken from an external input or from one of several internal sources and optionally inverted, can start the timer on its rising edge, stop it on its falling edge and reload the count on its rising edge. A capture path can therefore run only while a data-valid line is high and realign itself each time that line returns. Pin and trigger pass through a synchronizer into the module clock domain before any edge is taken from them.

The configuration inputs are static. They are changed only while `rst_n` is low.

Top module: `gated_tick_timer`

## Requirements
- R1: While `rst_n` is low, `tmr_out`, `shift_clk` and `xfer_pulse` are 0 and the timer is stopped.
- R2: Wide mode (`cfg_mode` 0 or 3): a step at count 0 reloads `cfg_cmp`, toggles `tmr_out` and raises `xfer_pulse` for one cycle. Any other step subtracts one, so with step source clock the transfers are `cfg_cmp`+1 cycles apart.
- R3: Split mode (`cfg_mode` 1, low byte = bits 7:0): a step with low byte 0 toggles `tmr_out` and reloads the low byte from `cfg_cmp[7:0]`. It also decrements the high byte, or, if the high byte is 0, reloads it from `cfg_cmp[15:8]` and raises `xfer_pulse`.
- R4: PWM mode (`cfg_mode` 2): while `tmr_out` is 1 the low byte counts down, and a step at low byte 0 drives `tmr_out` to 0 and reloads the low byte. While `tmr_out` is 0 the high byte counts down, and a step at high byte 0 drives `tmr_out` to 1, reloads the high byte and raises `xfer_pulse`.
- R5: `cfg_dec` selects the step source: 0 the module clock, 1 every edge of the synchronized pin, 2 every rising edge of the synchronized trigger, 3 none. With 1, `shift_clk` is the synchronized pin level. Otherwise it is `tmr_out`.
- R6: With pin stepping in wide mode and `cfg_cmp` = 31, one transfer occurs per 16 pin periods.
- R7: With `cfg_ena_rise` = 1, a stopped timer starts on a trigger rising edge. With 0, it starts on the next cycle by itself. With `cfg_dis_fall` = 1, a running timer stops on a trigger falling edge.
- R8: With `cfg_rst_rise` = 1, a trigger rising edge reloads the count from `cfg_cmp` without changing `tmr_out`. A step in the same cycle is dropped.
- R9: With `cfg_trg_int` = 1, the trigger is `trg_int[cfg_trg_sel]`, and `trg_ext` then has no effect. With 0, the trigger is `trg_ext`. With `cfg_trg_inv` = 1, the selected trigger is inverted before synchronization.
- R10: Each start sets `tmr_out` to `cfg_out_hi`. The first start after reset also loads the count from `cfg_cmp`. Later starts resume the held count.
- R11: A pin or trigger change applied between clock edges first affects the counter and `xfer_pulse` at the third rising clock edge. It first affects `shift_clk` at the second edge.
- R12: While the timer is stopped, `shift_clk` stays 0, no `xfer_pulse` occurs, and the count holds except for a reload under R8 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External count/clock pin, asynchronous |
| trg_ext | input | 1 | External trigger, asynchronous |
| trg_int | input | NINT | Internal trigger sources |
| cfg_mode | input | 2 | 0/3 wide, 1 split, 2 PWM |
| cfg_dec | input | 2 | Step source: 0 clock, 1 pin edges, 2 trigger rises, 3 none |
| cfg_trg_int | input | 1 | 1 selects an internal trigger source |
| cfg_trg_sel | input | SEL_W | Internal trigger index |
| cfg_trg_inv | input | 1 | Invert the selected trigger |
| cfg_ena_rise | input | 1 | Start on trigger rise (else start by itself) |
| cfg_dis_fall | input | 1 | Stop on trigger fall |
| cfg_rst_rise | input | 1 | Reload count on trigger rise |
| cfg_out_hi | input | 1 | Output level taken at each start |
| cfg_cmp | input | 2*HALF_W | Compare / reload value |
| tmr_out | output | 1 | Timer output level |
| shift_clk | output | 1 | Shift clock for the shifter bank |
| xfer_pulse | output | 1 | One-cycle shifter/buffer transfer strobe |

## Verification
The bench builds the timer with HALF_W = 8, NINT = 4 and a two-stage synchronizer. These are the sizes at which a compare value of 31 and byte-split values such as 0x0201 and 0x0302 give transfer periods of only a few dozen cycles. A run therefore covers many complete transfer periods in every mode, and the byte-boundary reloads of the split and PWM modes are exercised. With four internal sources the inverted internal trigger path is reachable through index 2 while `trg_ext` is also driven. The three-edge input latency is short enough to be checked edge by edge.

// File: rtl/gtt_pkg.sv
package gtt_pkg;

  typedef enum logic [1:0] {
    CM_WIDE  = 2'd0,
    CM_SPLIT = 2'd1,
    CM_PWM   = 2'd2,
    CM_WIDE2 = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    DS_CLK  = 2'd0,
    DS_PIN  = 2'd1,
    DS_TRG  = 2'd2,
    DS_NONE = 2'd3
  } dsrc_e;

endpackage

// File: rtl/gtt_sync.sv
module gtt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [STAGES-1:0][W-1:0] stg;

  // stage 0 captures the asynchronous input, later stages settle it
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

  // previous settled value, used for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= q;
  end

endmodule

// File: rtl/gtt_count.sv
module gtt_count
  import gtt_pkg::*;
#(
  parameter  int HALF_W = 8,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cmp,
  input  logic             tick,
  input  logic             load,
  input  logic             set_out,
  input  logic             out_init,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o,
  output logic             xfer_o
);

  // one step of the counter: returns {transfer, new output, new count}
  function automatic logic [CNT_W+1:0] advance(
    input logic [CNT_W-1:0] c,
    input logic             o,
    input logic [1:0]       m,
    input logic [CNT_W-1:0] r
  );
    logic [HALF_W-1:0] lo, hi, nlo, nhi;
    logic [CNT_W-1:0]  nc;
    logic              no, x;
    lo  = c[HALF_W-1:0];
    hi  = c[CNT_W-1:HALF_W];
    nlo = lo;
    nhi = hi;
    no  = o;
    x   = 1'b0;
    nc  = c;
    case (cmode_e'(m))
      CM_SPLIT: begin
        if (lo == '0) begin
          no  = ~o;
          nlo = r[HALF_W-1:0];
          if (hi == '0) begin
            nhi = r[CNT_W-1:HALF_W];
            x   = 1'b1;
          end else begin
            nhi = hi - 1'b1;
          end
        end else begin
          nlo = lo - 1'b1;
        end
        nc = {nhi, nlo};
      end
      CM_PWM: begin
        if (o) begin
          if (lo == '0) begin
            no  = 1'b0;
            nlo = r[HALF_W-1:0];
          end else begin
            nlo = lo - 1'b1;
          end
        end else begin
          if (hi == '0) begin
            no  = 1'b1;
            nhi = r[CNT_W-1:HALF_W];
            x   = 1'b1;
          end else begin
            nhi = hi - 1'b1;
          end
        end
        nc = {nhi, nlo};
      end
      default: begin
        if (c == '0) begin
          nc = r;
          no = ~o;
          x  = 1'b1;
        end else begin
          nc = c - 1'b1;
        end
      end
    endcase
    return {x, no, nc};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             xfer_q;
  logic [CNT_W+1:0] nxt;

  assign nxt = advance(cnt_q, out_q, mode, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (load) begin
        cnt_q <= cmp;
      end else if (tick) begin
        cnt_q  <= nxt[CNT_W-1:0];
        xfer_q <= nxt[CNT_W+1];
      end
      if (set_out)             out_q <= out_init;
      else if (tick && !load)  out_q <= nxt[CNT_W];
    end
  end

  assign cnt_o  = cnt_q;
  assign out_o  = out_q;
  assign xfer_o = xfer_q;

endmodule

// File: rtl/gated_tick_timer.sv
module gated_tick_timer
  import gtt_pkg::*;
#(
  parameter  int HALF_W      = 8,
  parameter  int NINT        = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int CNT_W       = 2 * HALF_W,
  localparam int SEL_W       = (NINT > 1) ? $clog2(NINT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             trg_ext,
  input  logic [NINT-1:0]  trg_int,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_dec,
  input  logic             cfg_trg_int,
  input  logic [SEL_W-1:0] cfg_trg_sel,
  input  logic             cfg_trg_inv,
  input  logic             cfg_ena_rise,
  input  logic             cfg_dis_fall,
  input  logic             cfg_rst_rise,
  input  logic             cfg_out_hi,
  input  logic [CNT_W-1:0] cfg_cmp,
  output logic             tmr_out,
  output logic             shift_clk,
  output logic             xfer_pulse
);

  // trigger selection and polarity, before synchronization
  logic trg_raw;
  assign trg_raw = (cfg_trg_int ? trg_int[cfg_trg_sel] : trg_ext) ^ cfg_trg_inv;

  logic [1:0] s_now, s_old;
  gtt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({trg_raw, pin_in}),
    .q      (s_now),
    .q_prev (s_old)
  );

  // named events, visible to the checker
  logic pin_s, pin_edge, trg_rise, trg_fall;
  assign pin_s    = s_now[0];
  assign pin_edge = s_now[0] ^ s_old[0];
  assign trg_rise = s_now[1] & ~s_old[1];
  assign trg_fall = ~s_now[1] & s_old[1];

  logic tick_src;
  always_comb begin
    case (dsrc_e'(cfg_dec))
      DS_CLK:  tick_src = 1'b1;
      DS_PIN:  tick_src = pin_edge;
      DS_TRG:  tick_src = trg_rise;
      default: tick_src = 1'b0;
    endcase
  end

  logic run_q, loaded_q;
  logic en_evt, dis_evt, rst_evt, load_evt, step_evt;
  assign en_evt   = ~run_q & (cfg_ena_rise ? trg_rise : 1'b1);
  assign dis_evt  = run_q & cfg_dis_fall & trg_fall;
  assign rst_evt  = cfg_rst_rise & trg_rise;
  assign load_evt = rst_evt | (en_evt & ~loaded_q);
  assign step_evt = run_q & tick_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      if (en_evt)       run_q <= 1'b1;
      else if (dis_evt) run_q <= 1'b0;
      if (load_evt)     loaded_q <= 1'b1;
    end
  end

  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  gtt_count #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .cmp      (cfg_cmp),
    .tick     (step_evt),
    .load     (load_evt),
    .set_out  (en_evt),
    .out_init (cfg_out_hi),
    .cnt_o    (cnt_q),
    .out_o    (out_q),
    .xfer_o   (xfer_pulse)
  );

  assign tmr_out   = out_q;
  assign shift_clk = run_q & ((dsrc_e'(cfg_dec) == DS_PIN) ? pin_s : out_q);

endmodule

// File: rtl/gtt_check.sv
module gtt_check #(
  parameter  int HALF_W = 8,
  localparam int CNT_W  = 2 * HALF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cmp,
  input logic             run,
  input logic             en_evt,
  input logic             dis_evt,
  input logic             rst_evt,
  input logic             load_evt,
  input logic [CNT_W-1:0] cnt,
  input logic             tmr_out,
  input logic             xfer_pulse
);

  a_r7_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    en_evt |=> run);

  a_r7_stop_takes: assert property (@(posedge clk) disable iff (!rst_n)
    dis_evt |=> !run);

  a_r12_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_evt) |=> $stable(cnt));

  a_r12_no_idle_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !xfer_pulse);

  a_r2_wide_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && (mode == 2'd0 || mode == 2'd3)) |-> (tmr_out != $past(tmr_out)));

  a_r3_split_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && mode == 2'd1) |-> (tmr_out != $past(tmr_out)));

  a_r4_pwm_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pulse && mode == 2'd2) |-> (tmr_out && !$past(tmr_out)));

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !en_evt) |=> ((cnt == $past(cmp)) && $stable(tmr_out)));

endmodule

bind gated_tick_timer gtt_check #(.HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (cfg_mode),
  .cmp        (cfg_cmp),
  .run        (run_q),
  .en_evt     (en_evt),
  .dis_evt    (dis_evt),
  .rst_evt    (rst_evt),
  .load_evt   (load_evt),
  .cnt        (cnt_q),
  .tmr_out    (tmr_out),
  .xfer_pulse (xfer_pulse)
);

// File: tb/gated_tick_timer_test.sv
module gated_tick_timer_test;

  localparam int HW = 8;
  localparam int NI = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          pin_in = 1'b0;
  logic          trg_ext = 1'b0;
  logic [NI-1:0] trg_int = '0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [1:0]    cfg_dec = 2'd0;
  logic          cfg_trg_int = 1'b0;
  logic [1:0]    cfg_trg_sel = 2'd0;
  logic          cfg_trg_inv = 1'b0;
  logic          cfg_ena_rise = 1'b0;
  logic          cfg_dis_fall = 1'b0;
  logic          cfg_rst_rise = 1'b0;
  logic          cfg_out_hi = 1'b0;
  logic [15:0]   cfg_cmp = 16'd0;
  logic          tmr_out, shift_clk, xfer_pulse;

  gated_tick_timer #(.HALF_W(HW), .NINT(NI), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trg_ext(trg_ext), .trg_int(trg_int),
    .cfg_mode(cfg_mode), .cfg_dec(cfg_dec), .cfg_trg_int(cfg_trg_int),
    .cfg_trg_sel(cfg_trg_sel), .cfg_trg_inv(cfg_trg_inv), .cfg_ena_rise(cfg_ena_rise),
    .cfg_dis_fall(cfg_dis_fall), .cfg_rst_rise(cfg_rst_rise), .cfg_out_hi(cfg_out_hi),
    .cfg_cmp(cfg_cmp), .tmr_out(tmr_out), .shift_clk(shift_clk), .xfer_pulse(xfer_pulse)
  );

  int    checks = 0;
  int    errors = 0;
  int    xfer_cnt = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_p1, m_p2, m_pp, m_t1, m_t2, m_tp;
  bit m_run, m_loaded, m_out, m_x;
  int m_hi, m_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_pp = 0; m_t1 = 0; m_t2 = 0; m_tp = 0;
      m_run = 0; m_loaded = 0; m_out = 0; m_x = 0; m_hi = 0; m_lo = 0;
    end else begin
      bit rise, fall, pedge, step, start, stop, realign, raw;
      int v;
      rise  = m_t2 && !m_tp;
      fall  = !m_t2 && m_tp;
      pedge = m_p2 != m_pp;
      case (cfg_dec)
        2'd0: step = 1;
        2'd1: step = pedge;
        2'd2: step = rise;
        default: step = 0;
      endcase
      start   = !m_run && (cfg_ena_rise ? rise : 1'b1);
      stop    = m_run && cfg_dis_fall && fall;
      realign = cfg_rst_rise && rise;
      m_x = 0;
      if (realign || (start && !m_loaded)) begin
        m_hi = cfg_cmp / 256; m_lo = cfg_cmp % 256; m_loaded = 1;
      end else if (m_run && step) begin
        if (cfg_mode == 2'd1) begin
          if (m_lo > 0) m_lo--;
          else begin
            m_out = !m_out; m_lo = cfg_cmp % 256;
            if (m_hi > 0) m_hi--;
            else begin m_hi = cfg_cmp / 256; m_x = 1; end
          end
        end else if (cfg_mode == 2'd2) begin
          if (m_out) begin
            if (m_lo > 0) m_lo--;
            else begin m_out = 0; m_lo = cfg_cmp % 256; end
          end else begin
            if (m_hi > 0) m_hi--;
            else begin m_out = 1; m_hi = cfg_cmp / 256; m_x = 1; end
          end
        end else begin
          v = m_hi * 256 + m_lo;
          if (v > 0) v--;
          else begin v = cfg_cmp; m_out = !m_out; m_x = 1; end
          m_hi = v / 256; m_lo = v % 256;
        end
      end
      if (start) m_out = cfg_out_hi;
      if (start) m_run = 1;
      else if (stop) m_run = 0;
      raw = (cfg_trg_int ? trg_int[cfg_trg_sel] : trg_ext) ^ cfg_trg_inv;
      m_pp = m_p2; m_p2 = m_p1; m_p1 = pin_in;
      m_tp = m_t2; m_t2 = m_t1; m_t1 = raw;
    end
  end

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk(cur_req, "tmr_out", tmr_out, m_out);
      chk(cur_req, "shift_clk", shift_clk, m_run && (cfg_dec == 2'd1 ? m_p2 : m_out));
      chk(cur_req, "xfer_pulse", xfer_pulse, m_x);
      if (xfer_pulse) xfer_cnt++;
    end
  end

  // automatic pin toggling
  bit pin_auto = 0;
  int pin_half = 2;
  int pin_ph = 0;
  always @(negedge clk) begin
    if (pin_auto) begin
      pin_ph++;
      if (pin_ph >= pin_half) begin pin_ph = 0; pin_in <= ~pin_in; end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic measure_gap(output int gap);
    int n;
    n = 0;
    do begin @(posedge clk); #3; n++; end while (!xfer_pulse && n < 3000);
    gap = 0;
    do begin @(posedge clk); #3; gap++; end while (!xfer_pulse && gap < 3000);
  endtask

  task automatic first_after_edge(output int n);
    n = 0;
    do begin @(posedge clk); #3; n++; end while (!(xfer_pulse && n > 3) && n < 3000);
  endtask

  initial begin
    int g, hc, sc;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "tmr_out in reset", tmr_out, 0);
    chk("R1", "shift_clk in reset", shift_clk, 0);
    chk("R1", "xfer_pulse in reset", xfer_pulse, 0);

    // R2 / R10: wide mode on module clock
    cur_req = "R2";
    cfg_mode = 2'd0; cfg_dec = 2'd0; cfg_cmp = 16'd5; cfg_out_hi = 1'b0;
    do_reset();
    @(posedge clk); #3;
    chk("R10", "start level low", tmr_out, 0);
    measure_gap(g);
    chk("R2", "wide gap cmp=5", g, 6);
    measure_gap(g);
    chk("R2", "wide gap repeat", g, 6);

    // R3: split mode
    cur_req = "R3";
    cfg_mode = 2'd1; cfg_cmp = 16'h0201;
    do_reset();
    measure_gap(g);
    chk("R3", "split gap 0x0201", g, 6);

    // R4 / R10: PWM starting high
    cur_req = "R4";
    cfg_mode = 2'd2; cfg_cmp = 16'h0302; cfg_out_hi = 1'b1;
    do_reset();
    @(posedge clk); #3;
    chk("R10", "start level high", tmr_out, 1);
    measure_gap(g);
    chk("R4", "pwm period 0x0302", g, 7);
    hc = tmr_out;
    repeat (6) begin @(posedge clk); #3; hc += tmr_out; end
    chk("R4", "pwm high samples", hc, 3);

    // R5 / R6 / R7 / R12: pin stepping gated by external trigger
    cur_req = "R6";
    cfg_mode = 2'd0; cfg_dec = 2'd1; cfg_cmp = 16'd31; cfg_out_hi = 1'b0;
    cfg_ena_rise = 1'b1; cfg_dis_fall = 1'b1;
    do_reset();
    pin_half = 2; pin_auto = 1;
    repeat (10) @(negedge clk);
    @(posedge clk); #3;
    chk("R7", "idle before trigger rise", shift_clk, 0);
    @(negedge clk); trg_ext = 1'b1;
    measure_gap(g);
    chk("R6", "16 pin periods per transfer", g, 64);
    measure_gap(g);
    chk("R6", "16 pin periods repeat", g, 64);
    cur_req = "R12";
    @(negedge clk); trg_ext = 1'b0;
    repeat (6) @(negedge clk);
    hc = 0; sc = 0;
    repeat (200) begin @(posedge clk); #3; hc += xfer_pulse; sc += shift_clk; end
    chk("R12", "no transfers while stopped", hc, 0);
    chk("R12", "no shift clock while stopped", sc, 0);
    cur_req = "R7";
    @(negedge clk); trg_ext = 1'b1;
    repeat (150) @(negedge clk);
    pin_auto = 0;

    // R8 / R9: realign via inverted internal trigger index 2
    cur_req = "R8";
    cfg_mode = 2'd1; cfg_dec = 2'd0; cfg_cmp = 16'h0103;
    cfg_ena_rise = 1'b0; cfg_dis_fall = 1'b0; cfg_rst_rise = 1'b1;
    cfg_trg_int = 1'b1; cfg_trg_sel = 2'd2; cfg_trg_inv = 1'b1;
    trg_int = 4'b1111; trg_ext = 1'b0;
    do_reset();
    repeat (17) @(negedge clk);
    trg_int[2] = 1'b0;
    first_after_edge(g);
    chk("R8", "transfer 11 edges after realign", g, 11);
    @(negedge clk); trg_int[2] = 1'b1;
    repeat (23) @(negedge clk);
    trg_int[2] = 1'b0;
    first_after_edge(g);
    chk("R9", "internal inverted trigger realigns", g, 11);
    // R9: external trigger edges are ignored while internal is selected
    @(negedge clk); trg_int[2] = 1'b1;
    repeat (9) @(negedge clk);
    trg_ext = 1'b1;
    repeat (2) @(negedge clk);
    trg_ext = 1'b0;
    repeat (2) @(negedge clk);
    trg_ext = 1'b1;
    g = 0;
    do begin @(posedge clk); #3; g++; end while (!xfer_pulse && g < 3000);
    chk("R9", "trg_ext ignored: next transfer not at 11", (g == 11) ? 1 : 0, 0);
    repeat (60) @(negedge clk);

    // R5: trigger rising edges as step source
    cur_req = "R5";
    cfg_mode = 2'd0; cfg_dec = 2'd2; cfg_cmp = 16'd2; cfg_rst_rise = 1'b0;
    cfg_trg_int = 1'b0; cfg_trg_inv = 1'b0; trg_ext = 1'b0;
    do_reset();
    repeat (4) @(negedge clk);
    xfer_cnt = 0;
    repeat (9) begin
      trg_ext = 1'b1; repeat (5) @(negedge clk);
      trg_ext = 1'b0; repeat (5) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk("R5", "3 transfers per 9 trigger rises", xfer_cnt, 3);

    // R11: synchronizer latency with pin stepping, cmp 0
    cur_req = "R11";
    cfg_dec = 2'd1; cfg_cmp = 16'd0; pin_in = 1'b0;
    do_reset();
    repeat (10) @(negedge clk);
    pin_in = 1'b1;
    @(posedge clk); #3;
    chk("R11", "edge1 xfer", xfer_pulse, 0);
    chk("R11", "edge1 shift_clk", shift_clk, 0);
    @(posedge clk); #3;
    chk("R11", "edge2 xfer", xfer_pulse, 0);
    chk("R5", "edge2 shift_clk follows pin", shift_clk, 1);
    @(posedge clk); #3;
    chk("R11", "edge3 xfer", xfer_pulse, 1);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule